// File: doc/BRIEF.md
# Debug-Gated Fuse Key Vault

This block keeps three secret cipher keys that are programmed into a fuse array. After reset it walks the fuse array one 32-bit word at a time and fills three internal 128-bit key registers. Once the fill is complete, a two-bit select input picks one of the keys and drives it to a downstream cipher engine. A small read port lets software fetch individual key words, but only when the requester is flagged as privileged.

A debug-mode input isolates the secrets. While it is high, each per-key view is forced to zero. The selected-key output is also forced to zero by a separate gate of its own. Register reads return zero and raise a violation pulse. The key registers keep their contents through debug, so normal service resumes without a new fuse pass as soon as debug mode drops.

Top module: `fuse_key_vault`

## Requirements
- R1: After reset the block raises `fuse_req` and fetches fuse words in ascending address order, 0 through 11. Each word is taken in the cycle `fuse_rvalid` is high. Word address 4*k+w becomes bits [32*w+31:32*w] of key k. `load_done` rises after the twelfth word and stays high until reset.
- R2: While `load_done` is low, `key_out` is zero and `key_valid` is low.
- R3: After loading, with debug low and `key_sel` equal to 0, 1 or 2, `key_out` equals the chosen key and `key_valid` is high in the same cycle.
- R4: The select code 3 is reserved. It gives a zero `key_out` with `key_valid` low.
- R5: While `dbg_mode` is high, all three key slices of `key_views` are zero in the same cycle. Slice k occupies bits [128*k+127:128*k].
- R6: While `dbg_mode` is high, `key_out` is zero and `key_valid` is low in the same cycle, for every select value.
- R7: Debug mode does not alter the stored keys. After `dbg_mode` falls, `key_out` and `key_views` show the loaded keys again without a new fuse pass.
- R8: A read with `rd_en` high, `rd_priv` high, debug low and `rd_addr` below 12 returns fuse word `rd_addr` on `rd_data` one cycle later. That cycle has `rd_valid` high and `access_viol` low.
- R9: A read that is unprivileged or made while `dbg_mode` is high returns zero on `rd_data` one cycle later. In that cycle `rd_valid` and `access_viol` are both high. `access_viol` is high only in cycles that answer such a read.
- R10: A privileged read at address 12 or above, outside debug, returns zero with `access_viol` low.
- R11: `fuse_req` is low whenever `load_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fuse_req | output | 1 | Fuse fetch in progress |
| fuse_addr | output | 4 | Fuse word address being fetched |
| fuse_rdata | input | 32 | Fuse word data |
| fuse_rvalid | input | 1 | Fuse word data valid for the current address |
| load_done | output | 1 | All key words loaded |
| key_sel | input | 2 | Key select, 3 reserved |
| dbg_mode | input | 1 | Debug state, isolates all secrets |
| key_out | output | 128 | Selected key to the cipher engine |
| key_valid | output | 1 | key_out carries a usable key |
| key_views | output | 384 | Gated per-key views, key k in slice k |
| rd_en | input | 1 | Read request |
| rd_addr | input | 4 | Read word address |
| rd_priv | input | 1 | Requester is privileged |
| rd_data | output | 32 | Read result |
| rd_valid | output | 1 | Read result valid, one cycle after rd_en |
| access_viol | output | 1 | Read refused, one cycle pulse |

## Verification
The assertions assume the fuse source raises `fuse_rvalid` only while `fuse_req` is high, with data matching the address presented. The bench's fuse model answers only a pending request and computes each word from the address it sees. The read assertions assume `rd_en` and its qualifiers are stable around each edge. The bench drives them on the falling edge and holds `dbg_mode` steady across each read, so that the one-cycle response is attributed to the request that caused it.

// File: rtl/fkv_pkg.sv
package fkv_pkg;
   typedef enum logic [0:0] {
      LD_FETCH = 1'b0,
      LD_DONE  = 1'b1
   } fkv_load_e;
endpackage

// File: rtl/fkv_loader.sv
module fkv_loader #(
   parameter int TOTAL_WORDS = 12,
   parameter int ADDR_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fuse_rvalid,
   output logic              fuse_req,
   output logic [ADDR_W-1:0] fuse_addr,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_idx,
   output logic              load_done
);
   import fkv_pkg::*;

   localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(TOTAL_WORDS - 1);

   fkv_load_e         state_q;
   logic [ADDR_W-1:0] cnt_q;

   assign fuse_req  = (state_q == LD_FETCH);
   assign fuse_addr = cnt_q;
   assign wr_en     = fuse_req & fuse_rvalid;
   assign wr_idx    = cnt_q;
   assign load_done = (state_q == LD_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LD_FETCH;
         cnt_q   <= '0;
      end else if (wr_en) begin
         if (cnt_q == LAST_IDX) begin
            state_q <= LD_DONE;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/fkv_store.sv
module fkv_store #(
   parameter int TOTAL_WORDS = 12,
   parameter int FUSE_W      = 32,
   parameter int ADDR_W      = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_idx,
   input  logic [FUSE_W-1:0]             wr_data,
   output logic [TOTAL_WORDS*FUSE_W-1:0] words_flat
);
   for (genvar i = 0; i < TOTAL_WORDS; i++) begin : g_word
      logic [FUSE_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (wr_en && (wr_idx == ADDR_W'(i))) begin
            word_q <= wr_data;
         end
      end
      assign words_flat[i*FUSE_W +: FUSE_W] = word_q;
   end
endmodule

// File: rtl/fkv_gate.sv
module fkv_gate #(
   parameter int NUM_KEYS = 3,
   parameter int KEY_W    = 128,
   parameter int SEL_W    = 2
) (
   input  logic [NUM_KEYS*KEY_W-1:0] keys_raw,
   input  logic [SEL_W-1:0]          key_sel,
   input  logic                      dbg_mode,
   input  logic                      load_done,
   output logic [NUM_KEYS*KEY_W-1:0] key_views,
   output logic [KEY_W-1:0]          key_out,
   output logic                      key_valid
);
   logic [KEY_W-1:0] picked;
   logic             sel_ok;

   // Each key path is isolated on its own.
   for (genvar k = 0; k < NUM_KEYS; k++) begin : g_view
      assign key_views[k*KEY_W +: KEY_W] =
         dbg_mode ? '0 : keys_raw[k*KEY_W +: KEY_W];
   end

   always_comb begin
      picked = '0;
      for (int k = 0; k < NUM_KEYS; k++) begin
         if (key_sel == SEL_W'(k)) begin
            picked = key_views[k*KEY_W +: KEY_W];
         end
      end
   end

   assign sel_ok    = (int'(key_sel) < NUM_KEYS);
   // The output carries a second, separate debug gate.
   assign key_valid = load_done & sel_ok & ~dbg_mode;
   assign key_out   = (key_valid && !dbg_mode) ? picked : '0;
endmodule

// File: rtl/fkv_regport.sv
module fkv_regport #(
   parameter int TOTAL_WORDS = 12,
   parameter int FUSE_W      = 32,
   parameter int ADDR_W      = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [TOTAL_WORDS*FUSE_W-1:0] words_flat,
   input  logic                          rd_en,
   input  logic [ADDR_W-1:0]             rd_addr,
   input  logic                          rd_priv,
   input  logic                          dbg_mode,
   output logic [FUSE_W-1:0]             rd_data,
   output logic                          rd_valid,
   output logic                          access_viol
);
   logic [FUSE_W-1:0] word_sel;
   logic              in_range;
   logic              denied;
   logic [FUSE_W-1:0] data_q;
   logic              valid_q;
   logic              viol_q;

   assign in_range = (int'(rd_addr) < TOTAL_WORDS);
   assign denied   = ~rd_priv | dbg_mode;

   always_comb begin
      word_sel = '0;
      for (int i = 0; i < TOTAL_WORDS; i++) begin
         if (rd_addr == ADDR_W'(i)) begin
            word_sel = words_flat[i*FUSE_W +: FUSE_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         valid_q <= 1'b0;
         viol_q  <= 1'b0;
      end else begin
         valid_q <= rd_en;
         viol_q  <= rd_en & denied;
         data_q  <= (rd_en && !denied && in_range) ? word_sel : '0;
      end
   end

   assign rd_data     = dbg_mode ? '0 : data_q;
   assign rd_valid    = valid_q;
   assign access_viol = viol_q;
endmodule

// File: rtl/fuse_key_vault.sv
module fuse_key_vault #(
   parameter int NUM_KEYS = 3,
   parameter int KEY_W    = 128,
   parameter int FUSE_W   = 32,
   parameter int SEL_W    = 2,
   parameter int ADDR_W   = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   output logic                      fuse_req,
   output logic [ADDR_W-1:0]         fuse_addr,
   input  logic [FUSE_W-1:0]         fuse_rdata,
   input  logic                      fuse_rvalid,
   output logic                      load_done,
   input  logic [SEL_W-1:0]          key_sel,
   input  logic                      dbg_mode,
   output logic [KEY_W-1:0]          key_out,
   output logic                      key_valid,
   output logic [NUM_KEYS*KEY_W-1:0] key_views,
   input  logic                      rd_en,
   input  logic [ADDR_W-1:0]         rd_addr,
   input  logic                      rd_priv,
   output logic [FUSE_W-1:0]         rd_data,
   output logic                      rd_valid,
   output logic                      access_viol
);
   localparam int WORDS_PER_KEY = KEY_W / FUSE_W;
   localparam int TOTAL_WORDS   = NUM_KEYS * WORDS_PER_KEY;

   if (KEY_W % FUSE_W != 0) begin : g_bad_width
      $error("KEY_W must be a multiple of FUSE_W");
   end
   if (NUM_KEYS >= (1 << SEL_W)) begin : g_bad_sel
      $error("SEL_W must leave at least one reserved code");
   end
   if (TOTAL_WORDS > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the word count");
   end

   logic                          wr_en;
   logic [ADDR_W-1:0]             wr_idx;
   logic [TOTAL_WORDS*FUSE_W-1:0] words_flat;

   fkv_loader #(.TOTAL_WORDS(TOTAL_WORDS), .ADDR_W(ADDR_W)) u_loader (
      .clk(clk), .rst_n(rst_n), .fuse_rvalid(fuse_rvalid),
      .fuse_req(fuse_req), .fuse_addr(fuse_addr),
      .wr_en(wr_en), .wr_idx(wr_idx), .load_done(load_done)
   );

   fkv_store #(.TOTAL_WORDS(TOTAL_WORDS), .FUSE_W(FUSE_W), .ADDR_W(ADDR_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(fuse_rdata), .words_flat(words_flat)
   );

   fkv_gate #(.NUM_KEYS(NUM_KEYS), .KEY_W(KEY_W), .SEL_W(SEL_W)) u_gate (
      .keys_raw(words_flat), .key_sel(key_sel), .dbg_mode(dbg_mode),
      .load_done(load_done), .key_views(key_views),
      .key_out(key_out), .key_valid(key_valid)
   );

   fkv_regport #(.TOTAL_WORDS(TOTAL_WORDS), .FUSE_W(FUSE_W), .ADDR_W(ADDR_W)) u_regport (
      .clk(clk), .rst_n(rst_n), .words_flat(words_flat),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_priv(rd_priv), .dbg_mode(dbg_mode),
      .rd_data(rd_data), .rd_valid(rd_valid), .access_viol(access_viol)
   );
endmodule

// File: rtl/fuse_key_vault_chk.sv
module fuse_key_vault_chk #(
   parameter int NUM_KEYS = 3,
   parameter int KEY_W    = 128,
   parameter int FUSE_W   = 32,
   parameter int SEL_W    = 2,
   parameter int ADDR_W   = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      fuse_req,
   input logic [ADDR_W-1:0]         fuse_addr,
   input logic                      load_done,
   input logic [SEL_W-1:0]          key_sel,
   input logic                      dbg_mode,
   input logic [KEY_W-1:0]          key_out,
   input logic                      key_valid,
   input logic [NUM_KEYS*KEY_W-1:0] key_views,
   input logic                      rd_en,
   input logic                      rd_priv,
   input logic [FUSE_W-1:0]         rd_data,
   input logic                      rd_valid,
   input logic                      access_viol
);
   localparam int TOTAL_WORDS = NUM_KEYS * (KEY_W / FUSE_W);

   // R1
   load_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |=> load_done);

   // R1
   fetch_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fuse_req |-> (int'(fuse_addr) < TOTAL_WORDS));

   // R2
   preload_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_done |-> (!key_valid && key_out == '0));

   // R4
   reserved_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(key_sel) >= NUM_KEYS) |-> (!key_valid && key_out == '0));

   // R5
   views_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_mode |-> (key_views == '0));

   // R6
   out_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_mode |-> (key_out == '0 && !key_valid));

   // R9
   denied_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (!rd_priv || dbg_mode)) |=> (access_viol && rd_valid && rd_data == '0));

   // R9
   viol_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      access_viol |-> rd_valid);

   // R11
   fetch_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |-> !fuse_req);
endmodule

bind fuse_key_vault fuse_key_vault_chk #(
   .NUM_KEYS(NUM_KEYS), .KEY_W(KEY_W), .FUSE_W(FUSE_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .fuse_req(fuse_req), .fuse_addr(fuse_addr),
   .load_done(load_done), .key_sel(key_sel), .dbg_mode(dbg_mode),
   .key_out(key_out), .key_valid(key_valid), .key_views(key_views),
   .rd_en(rd_en), .rd_priv(rd_priv), .rd_data(rd_data),
   .rd_valid(rd_valid), .access_viol(access_viol)
);

// File: tb/fuse_key_vault_tb.sv
module fuse_key_vault_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         fuse_req;
   logic [3:0]   fuse_addr;
   logic [31:0]  fuse_rdata = '0;
   logic         fuse_rvalid = 1'b0;
   logic         load_done;
   logic [1:0]   key_sel = '0;
   logic         dbg_mode = 1'b0;
   logic [127:0] key_out;
   logic         key_valid;
   logic [383:0] key_views;
   logic         rd_en = 1'b0;
   logic [3:0]   rd_addr = '0;
   logic         rd_priv = 1'b0;
   logic [31:0]  rd_data;
   logic         rd_valid;
   logic         access_viol;

   int n_cmp = 0;
   int n_bad = 0;
   int fetches = 0;
   int cycles = 0;
   bit done_flag = 1'b0;

   typedef struct {
      logic [31:0] data;
      logic        viol;
      string       req;
   } exp_t;
   exp_t sb_q[$];

   always #10 clk = ~clk;

   fuse_key_vault u_dut (
      .clk(clk), .rst_n(rst_n), .fuse_req(fuse_req), .fuse_addr(fuse_addr),
      .fuse_rdata(fuse_rdata), .fuse_rvalid(fuse_rvalid), .load_done(load_done),
      .key_sel(key_sel), .dbg_mode(dbg_mode), .key_out(key_out),
      .key_valid(key_valid), .key_views(key_views), .rd_en(rd_en),
      .rd_addr(rd_addr), .rd_priv(rd_priv), .rd_data(rd_data),
      .rd_valid(rd_valid), .access_viol(access_viol)
   );

   function automatic logic [31:0] fw(int a);
      return {8'(a + 1), 8'hC3, 8'(a * 29), 8'h5A};
   endfunction

   function automatic logic [127:0] ek(int k);
      return {fw(4*k+3), fw(4*k+2), fw(4*k+1), fw(4*k)};
   endfunction

   task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // Fuse model: answers the pending address every other cycle (R1 order check).
   always @(negedge clk) begin
      if (rst_n && fuse_req && !fuse_rvalid) begin
         chk("R1 fetch order", 128'(fuse_addr), 128'(fetches));
         fuse_rdata  <= fw(int'(fuse_addr));
         fuse_rvalid <= 1'b1;
         fetches++;
      end else begin
         fuse_rvalid <= 1'b0;
      end
   end

   // Scoreboard monitor for the read port.
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (sb_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R8 unexpected read response actual=%h expected=none", rd_data);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            chk({e.req, " rd_data"}, 128'(rd_data), 128'(e.data));
            chk({e.req, " access_viol"}, 128'(access_viol), 128'(e.viol));
         end
      end else if (rst_n && access_viol) begin
         n_cmp++; n_bad++;
         $display("FAIL R9 stray violation actual=1 expected=0");
      end
   end

   // Watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done_flag) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
         finish_run();
      end
   end

   task automatic do_read(int addr, bit priv, logic [31:0] exp_data, bit exp_viol, string req);
      exp_t e;
      @(negedge clk);
      e.data = exp_data; e.viol = exp_viol; e.req = req;
      sb_q.push_back(e);
      rd_en   = 1'b1;
      rd_addr = 4'(addr);
      rd_priv = priv;
      @(negedge clk);
      rd_en   = 1'b0;
      rd_priv = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // Reset state
      chk("R2 reset load_done", 128'(load_done), 128'(0));
      chk("R2 reset key_valid", 128'(key_valid), 128'(0));
      chk("R2 reset key_out", key_out, '0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R2 mid-load key_valid", 128'(key_valid), 128'(0));
      chk("R2 mid-load key_out", key_out, '0);
      while (!load_done) @(negedge clk);
      chk("R1 fetch count", 128'(fetches), 128'(12));
      repeat (3) @(negedge clk);
      chk("R1 load_done held", 128'(load_done), 128'(1));
      chk("R11 fuse_req low", 128'(fuse_req), 128'(0));

      // Selection
      for (int k = 0; k < 3; k++) begin
         key_sel = 2'(k);
         #1;
         chk("R3 key_out", key_out, ek(k));
         chk("R3 key_valid", 128'(key_valid), 128'(1));
         chk("R1 key_views slice", key_views[k*128 +: 128], ek(k));
      end
      key_sel = 2'd3;
      #1;
      chk("R4 reserved key_out", key_out, '0);
      chk("R4 reserved key_valid", 128'(key_valid), 128'(0));

      // Debug isolation, same cycle
      @(negedge clk);
      key_sel = 2'd2;
      dbg_mode = 1'b1;
      #1;
      for (int k = 0; k < 3; k++)
         chk("R5 view dark", key_views[k*128 +: 128], '0);
      for (int s = 0; s < 4; s++) begin
         key_sel = 2'(s);
         #1;
         chk("R6 key_out dark", key_out, '0);
         chk("R6 key_valid low", 128'(key_valid), 128'(0));
      end
      do_read(5, 1'b1, 32'h0, 1'b1, "R9 debug priv read");
      repeat (2) @(negedge clk);
      dbg_mode = 1'b0;
      key_sel = 2'd1;
      #1;
      chk("R7 key_out restored", key_out, ek(1));
      chk("R7 view restored", key_views[2*128 +: 128], ek(2));
      chk("R7 no refetch", 128'(fuse_req), 128'(0));

      // Read port
      do_read(0, 1'b1, fw(0), 1'b0, "R8 read w0");
      do_read(7, 1'b1, fw(7), 1'b0, "R8 read w7");
      do_read(11, 1'b1, fw(11), 1'b0, "R8 read w11");
      do_read(4, 1'b0, 32'h0, 1'b1, "R9 unpriv read");
      do_read(12, 1'b1, 32'h0, 1'b0, "R10 out of range");
      do_read(15, 1'b1, 32'h0, 1'b0, "R10 top address");
      do_read(3, 1'b1, fw(3), 1'b0, "R8 read after deny");
      repeat (3) @(negedge clk);
      chk("R9 violation pulse ended", 128'(access_viol), 128'(0));
      chk("R8 scoreboard drained", 128'(sb_q.size()), 128'(0));
      done_flag = 1'b1;
      finish_run();
   end
endmodule